// File: doc/BRIEF.md
# Conditional Branch and Halfword Condition Unit

This unit resolves the two conditional branch forms of a byte-addressed processor with sixteen general registers and a 24-bit address space. The decoder hands it one instruction per cycle: an 8-bit opcode, a 4-bit condition mask, a register field, a base field, a 12-bit displacement and the current program counter. The unit names the registers it needs on two read ports. A register file outside the unit returns their contents in the same cycle. One cycle later the unit presents the branch decision and the next program counter.

The branch target depends on the form. In the register form, the target is the contents of the named register. In the indexed form, the target is base plus index plus an unsigned displacement, taken modulo 2^24. A field value of zero in either form stands for "no register". In that case register 0 is never addressed.

The unit also owns the 2-bit condition code. It updates the code from a 16-bit two's-complement add presented on a separate input. Overflow is detected by comparing the carry into the sign bit with the carry out of it.

Top module: `brc_unit`

## Requirements
- R1: After reset, `out_valid`, `taken`, `npc` and `cc` are all zero.
- R2: Opcode 0x07 is the register form. Its target is bits 23:0 of the register named by `reg_f`. When `reg_f` is 0 the branch is never taken, whatever the mask.
- R3: Opcode 0x47 is the indexed form. Its target is (index register, or 0 if `reg_f` is 0) + (base register, or 0 if `base_f` is 0) + zero-extended `disp`, modulo 2^24.
- R4: A read port is never enabled with register number 0. Port A carries `reg_f`. Port B carries `base_f` and is enabled only for the indexed form.
- R5: Mask bit k, numbered from the left, is `mask_f[3-k]`. Bit k is selected by condition code k. The branch is taken when the selected bit is 1.
- R6: A mask of 0 never branches. A mask of 15 always branches, subject to R2's zero-register rule.
- R7: When not taken, `npc` is `pc` plus 2 (opcode 0x07) or plus 4 (opcode 0x47), modulo 2^24.
- R8: On `add_valid`, `cc` becomes 3 on signed overflow. Otherwise it becomes 0 for a zero sum, 1 for a negative sum and 2 for a positive sum.
- R9: A branch issued in the same cycle as an add is decided with the condition code held before that add.
- R10: A valid instruction with any other opcode produces no `out_valid`.
- R11: `cc` holds its value in every cycle without `add_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Decoded operation code |
| mask_f | input | 4 | Condition mask field |
| reg_f | input | 4 | Target register (register form) or index register (indexed form) |
| base_f | input | 4 | Base register field |
| disp | input | 12 | Unsigned displacement |
| pc | input | 24 | Program counter of the instruction |
| rd_en_a | output | 1 | Read enable, port A |
| rd_sel_a | output | 4 | Register number, port A |
| rf_a_data | input | 32 | Read data, port A |
| rd_en_b | output | 1 | Read enable, port B |
| rd_sel_b | output | 4 | Register number, port B |
| rf_b_data | input | 32 | Read data, port B |
| add_valid | input | 1 | Halfword add present this cycle |
| add_a | input | 16 | Add operand A |
| add_b | input | 16 | Add operand B |
| out_valid | output | 1 | Branch result valid |
| taken | output | 1 | Branch taken |
| npc | output | 24 | Next program counter |
| cc | output | 2 | Condition code |

## Verification
A branch decision and a condition code update can land on the same clock edge. The branch must see the old code, and the new code must appear afterwards. The bench first sets the code to positive. It then issues an equal-mask branch together with an add that sums to zero, in one cycle. It expects the branch not taken and the code to read zero after the edge. It then repeats the setup with overflow and a mask that selects only overflow.

// File: rtl/brc_pkg.sv
// Package: shared constants and types for the branch unit.
// Assumes opcodes are 8 bits and the condition code is 2 bits.
package brc_pkg;
    localparam logic [7:0] OP_BR_REG = 8'h07;
    localparam logic [7:0] OP_BR_IDX = 8'h47;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2,
        CC_OVF  = 2'd3
    } cc_e;
endpackage

// File: rtl/brc_ea.sv
// Module: branch target generator.
// Register form: target is the low AW bits of port A data.
// Indexed form: target is index + base + disp modulo 2^AW; a disabled port adds 0.
// Assumes DW >= AW.
module brc_ea #(
    parameter int AW    = 24,
    parameter int DW    = 32,
    parameter int DISPW = 12
) (
    input  logic             is_idx,
    input  logic             a_en,
    input  logic             b_en,
    input  logic [DW-1:0]    a_data,
    input  logic [DW-1:0]    b_data,
    input  logic [DISPW-1:0] disp,
    output logic [AW-1:0]    target
);
    localparam int PADW = AW - DISPW;

    logic [AW-1:0] idx_term;
    logic [AW-1:0] base_term;

    // Select the target from the register or from the three-term sum.
    always_comb begin
        idx_term  = a_en ? a_data[AW-1:0] : '0;
        base_term = b_en ? b_data[AW-1:0] : '0;
        if (is_idx)
            target = idx_term + base_term + {{PADW{1'b0}}, disp};
        else
            target = a_data[AW-1:0];
    end
endmodule

// File: rtl/brc_cond.sv
// Module: mask test. Mask bit k (numbered from the left) lies at vector
// index MW-1-k and is selected when the condition code equals k.
module brc_cond #(
    parameter int MW = 4,
    localparam int CW = $clog2(MW)
) (
    input  logic [MW-1:0] mask,
    input  logic [CW-1:0] code,
    output logic          hit
);
    logic [MW-1:0] by_code;

    genvar k;
    generate
        for (k = 0; k < MW; k++) begin : g_rev
            assign by_code[k] = mask[MW-1-k];
        end
    endgenerate

    // Pick the mask bit addressed by the condition code.
    always_comb hit = by_code[code];
endmodule

// File: rtl/brc_hwadd.sv
// Module: two's-complement add of HW bits, producing the next condition code.
// Overflow is the XOR of the carry into and the carry out of the sign bit.
// Overflow takes priority over the sign and zero tests.
module brc_hwadd #(
    parameter int HW = 16
) (
    input  logic [HW-1:0] a,
    input  logic [HW-1:0] b,
    output logic [1:0]    cc_next
);
    import brc_pkg::*;

    logic [HW:0]   full;
    logic [HW-1:0] low;
    logic          c_out;
    logic          c_in_sign;

    // Form both carries and classify the result.
    always_comb begin
        full      = {1'b0, a} + {1'b0, b};
        low       = {1'b0, a[HW-2:0]} + {1'b0, b[HW-2:0]};
        c_out     = full[HW];
        c_in_sign = low[HW-1];
        if (c_out ^ c_in_sign)      cc_next = CC_OVF;
        else if (full[HW-1:0] == '0) cc_next = CC_ZERO;
        else if (full[HW-1])        cc_next = CC_NEG;
        else                        cc_next = CC_POS;
    end
endmodule

// File: rtl/brc_unit.sv
// Module: conditional branch and condition code unit (top).
// Decodes the two branch forms, drives register read ports, registers the
// taken flag and next PC one cycle after `valid`, and holds the condition code.
// Assumes a register file that returns read data in the same cycle.
// A branch decision uses the code held before any add arriving in the same cycle.
module brc_unit #(
    parameter int AW    = 24,
    parameter int DW    = 32,
    parameter int DISPW = 12,
    parameter int HW    = 16,
    parameter int RW    = 4,
    parameter int MW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [7:0]       opcode,
    input  logic [MW-1:0]    mask_f,
    input  logic [RW-1:0]    reg_f,
    input  logic [RW-1:0]    base_f,
    input  logic [DISPW-1:0] disp,
    input  logic [AW-1:0]    pc,
    output logic             rd_en_a,
    output logic [RW-1:0]    rd_sel_a,
    input  logic [DW-1:0]    rf_a_data,
    output logic             rd_en_b,
    output logic [RW-1:0]    rd_sel_b,
    input  logic [DW-1:0]    rf_b_data,
    input  logic             add_valid,
    input  logic [HW-1:0]    add_a,
    input  logic [HW-1:0]    add_b,
    output logic             out_valid,
    output logic             taken,
    output logic [AW-1:0]    npc,
    output logic [1:0]       cc
);
    import brc_pkg::*;

    localparam logic [AW-1:0] LEN_SHORT = AW'(2);
    localparam logic [AW-1:0] LEN_LONG  = AW'(4);

    logic          is_reg;
    logic          is_idx;
    logic          is_br;
    logic          hit;
    logic          take_d;
    logic [AW-1:0] target;
    logic [AW-1:0] seq_pc;
    logic [1:0]    cc_next;

    // Decode the opcode and gate the read ports away from register 0.
    always_comb begin
        is_reg   = valid && (opcode == OP_BR_REG);
        is_idx   = valid && (opcode == OP_BR_IDX);
        is_br    = is_reg || is_idx;
        rd_sel_a = reg_f;
        rd_sel_b = base_f;
        rd_en_a  = is_br && (reg_f != '0);
        rd_en_b  = is_idx && (base_f != '0);
    end

    brc_ea #(.AW(AW), .DW(DW), .DISPW(DISPW)) ea_i (
        .is_idx (is_idx),
        .a_en   (rd_en_a),
        .b_en   (rd_en_b),
        .a_data (rf_a_data),
        .b_data (rf_b_data),
        .disp   (disp),
        .target (target)
    );

    brc_cond #(.MW(MW)) cond_i (
        .mask (mask_f),
        .code (cc),
        .hit  (hit)
    );

    brc_hwadd #(.HW(HW)) add_i (
        .a       (add_a),
        .b       (add_b),
        .cc_next (cc_next)
    );

    // Decide the branch; the register form needs a real register to jump to.
    always_comb begin
        take_d = hit && (is_idx || (is_reg && (reg_f != '0)));
        seq_pc = pc + (is_idx ? LEN_LONG : LEN_SHORT);
    end

    // Register the branch result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            npc       <= '0;
        end else begin
            out_valid <= is_br;
            if (is_br) begin
                taken <= take_d;
                npc   <= take_d ? target : seq_pc;
            end
        end
    end

    // Hold the condition code, updating it only on an add.
    always_ff @(posedge clk) begin
        if (!rst_n)         cc <= CC_ZERO;
        else if (add_valid) cc <= cc_next;
    end
endmodule

// File: rtl/brc_unit_chk.sv
// Module: property checker for brc_unit, bound to every instance.
module brc_unit_chk #(
    parameter int AW = 24,
    parameter int HW = 16,
    parameter int RW = 4,
    parameter int MW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid,
    input logic [7:0]    opcode,
    input logic [MW-1:0] mask_f,
    input logic [RW-1:0] reg_f,
    input logic          rd_en_a,
    input logic [RW-1:0] rd_sel_a,
    input logic          rd_en_b,
    input logic [RW-1:0] rd_sel_b,
    input logic          add_valid,
    input logic [HW-1:0] add_a,
    input logic [HW-1:0] add_b,
    input logic          out_valid,
    input logic          taken,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] npc,
    input logic [1:0]    cc
);
    logic [HW-1:0] chk_sum;
    always_comb chk_sum = add_a + add_b;

    assert_no_r0_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_a |-> rd_sel_a != '0) and (rd_en_b |-> rd_sel_b != '0));

    assert_mask_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (opcode == 8'h07 || opcode == 8'h47) && mask_f == '0) |=> (out_valid && !taken));

    assert_mask_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && opcode == 8'h47 && mask_f == '1) |=> (out_valid && taken));

    assert_seq_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && opcode == 8'h07 && mask_f == '0) |=> (npc == $past(pc) + AW'(2)));

    assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (add_valid && add_a[HW-1] == add_b[HW-1] && chk_sum[HW-1] != add_a[HW-1]) |=> (cc == 2'd3));

    assert_other_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || (opcode != 8'h07 && opcode != 8'h47)) |=> !out_valid);

    assert_cc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !add_valid |=> $stable(cc));
endmodule

bind brc_unit brc_unit_chk #(.AW(AW), .HW(HW), .RW(RW), .MW(MW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (valid),
    .opcode    (opcode),
    .mask_f    (mask_f),
    .reg_f     (reg_f),
    .rd_en_a   (rd_en_a),
    .rd_sel_a  (rd_sel_a),
    .rd_en_b   (rd_en_b),
    .rd_sel_b  (rd_sel_b),
    .add_valid (add_valid),
    .add_a     (add_a),
    .add_b     (add_b),
    .out_valid (out_valid),
    .taken     (taken),
    .pc        (pc),
    .npc       (npc),
    .cc        (cc)
);

// File: tb/brc_unit_tb_top.sv
// Directed bench for brc_unit: one task per scenario, each checking itself.
module brc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [3:0]  mask_f = 4'h0;
    logic [3:0]  reg_f = 4'h0;
    logic [3:0]  base_f = 4'h0;
    logic [11:0] disp = 12'h000;
    logic [23:0] pc = 24'h0;
    logic        rd_en_a, rd_en_b;
    logic [3:0]  rd_sel_a, rd_sel_b;
    logic [31:0] rf_a_data, rf_b_data;
    logic        add_valid = 1'b0;
    logic [15:0] add_a = 16'h0, add_b = 16'h0;
    logic        out_valid, taken;
    logic [23:0] npc;
    logic [1:0]  cc;

    logic [31:0] regs [16];
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    assign rf_a_data = regs[rd_sel_a];
    assign rf_b_data = regs[rd_sel_b];

    brc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode),
        .mask_f(mask_f), .reg_f(reg_f), .base_f(base_f), .disp(disp), .pc(pc),
        .rd_en_a(rd_en_a), .rd_sel_a(rd_sel_a), .rf_a_data(rf_a_data),
        .rd_en_b(rd_en_b), .rd_sel_b(rd_sel_b), .rf_b_data(rf_b_data),
        .add_valid(add_valid), .add_a(add_a), .add_b(add_b),
        .out_valid(out_valid), .taken(taken), .npc(npc), .cc(cc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cc(input logic [15:0] a, input logic [15:0] b);
        add_valid = 1'b1; add_a = a; add_b = b;
        @(posedge clk); #2;
        add_valid = 1'b0;
    endtask

    task automatic issue(input logic [7:0] op, input logic [3:0] m, input logic [3:0] r,
                         input logic [3:0] b, input logic [11:0] d, input logic [23:0] p);
        valid = 1'b1; opcode = op; mask_f = m; reg_f = r; base_f = b; disp = d; pc = p;
        @(posedge clk); #2;
        valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out_valid", {31'b0, out_valid}, 0);
        chk("R1 taken", {31'b0, taken}, 0);
        chk("R1 npc", {8'b0, npc}, 0);
        chk("R1 cc", {30'b0, cc}, 0);
    endtask

    task automatic t_cc_add;
        set_cc(16'h6000, 16'h6000); chk("R8 overflow pos", {30'b0, cc}, 3);
        set_cc(16'h8000, 16'h8000); chk("R8 overflow neg zero sum", {30'b0, cc}, 3);
        set_cc(16'h0005, 16'hFFFB); chk("R8 zero", {30'b0, cc}, 0);
        set_cc(16'h0003, 16'hFFF6); chk("R8 negative", {30'b0, cc}, 1);
        set_cc(16'h0007, 16'h0008); chk("R8 positive", {30'b0, cc}, 2);
        add_a = 16'h0000; add_b = 16'h0000;
        @(posedge clk); #2;
        chk("R11 hold", {30'b0, cc}, 2);
    endtask

    task automatic t_mask_table;
        logic [15:0] ca [4];
        logic [15:0] cb [4];
        ca[0] = 16'h0001; cb[0] = 16'hFFFF;
        ca[1] = 16'h0000; cb[1] = 16'hFFFF;
        ca[2] = 16'h0001; cb[2] = 16'h0001;
        ca[3] = 16'h6000; cb[3] = 16'h6000;
        for (int c = 0; c < 4; c++) begin
            set_cc(ca[c], cb[c]);
            chk("R8 setup", {30'b0, cc}, c);
            for (int m = 0; m < 16; m++) begin
                logic [3:0] mv;
                logic       exp_t;
                mv = 4'(m);
                exp_t = mv[3 - c];
                issue(8'h47, mv, 4'd0, 4'd3, 12'h010, 24'h000100);
                chk("R5 valid", {31'b0, out_valid}, 1);
                chk("R5/R6 taken", {31'b0, taken}, {31'b0, exp_t});
                chk("R3/R7 npc", {8'b0, npc}, exp_t ? 32'h001010 : 32'h000104);
            end
        end
    endtask

    task automatic t_reg_form;
        issue(8'h07, 4'hF, 4'd8, 4'd0, 12'h000, 24'h000200);
        chk("R2 taken", {31'b0, taken}, 1);
        chk("R2 target", {8'b0, npc}, 32'h00ABCDEF);
        valid = 1'b1; opcode = 8'h07; mask_f = 4'hF; reg_f = 4'd0; pc = 24'h000300;
        #1;
        chk("R4 port A idle on field 0", {31'b0, rd_en_a}, 0);
        chk("R4 port B idle on reg form", {31'b0, rd_en_b}, 0);
        @(posedge clk); #2;
        valid = 1'b0;
        chk("R2 zero reg not taken", {31'b0, taken}, 0);
        chk("R7 short step", {8'b0, npc}, 32'h000302);
        issue(8'h07, 4'h0, 4'd8, 4'd0, 12'h000, 24'hFFFFFE);
        chk("R7 wrap", {8'b0, npc}, 0);
    endtask

    task automatic t_idx_form;
        set_cc(16'h0001, 16'h0001);
        issue(8'h47, 4'hF, 4'd0, 4'd0, 12'hFFF, 24'h0);
        chk("R3 no base no index", {8'b0, npc}, 32'h000FFF);
        issue(8'h47, 4'hF, 4'd8, 4'd3, 12'h004, 24'h0);
        chk("R3 base+index+disp", {8'b0, npc}, 32'hABDDF3);
        issue(8'h47, 4'hF, 4'd0, 4'd5, 12'h020, 24'h0);
        chk("R3 wrap", {8'b0, npc}, 32'h000010);
        issue(8'h47, 4'h0, 4'd0, 4'd5, 12'h020, 24'hFFFFFC);
        chk("R7 long wrap", {8'b0, npc}, 0);
    endtask

    task automatic t_same_cycle;
        set_cc(16'h0001, 16'h0001);
        valid = 1'b1; opcode = 8'h47; mask_f = 4'b1000; reg_f = 4'd0; base_f = 4'd3;
        disp = 12'h000; pc = 24'h000400;
        add_valid = 1'b1; add_a = 16'h0004; add_b = 16'hFFFC;
        @(posedge clk); #2;
        valid = 1'b0; add_valid = 1'b0;
        chk("R9 old code used", {31'b0, taken}, 0);
        chk("R9 npc", {8'b0, npc}, 32'h000404);
        chk("R9 new code", {30'b0, cc}, 0);
        valid = 1'b1; mask_f = 4'b0001;
        add_valid = 1'b1; add_a = 16'h6000; add_b = 16'h6000;
        @(posedge clk); #2;
        valid = 1'b0; add_valid = 1'b0;
        chk("R9 old zero code", {31'b0, taken}, 0);
        chk("R9 overflow after", {30'b0, cc}, 3);
    endtask

    task automatic t_other_op;
        issue(8'h58, 4'hF, 4'd8, 4'd3, 12'h000, 24'h0);
        chk("R10 no result", {31'b0, out_valid}, 0);
        issue(8'h47, 4'hF, 4'd0, 4'd0, 12'h123, 24'h0);
        valid = 1'b0; opcode = 8'h47;
        @(posedge clk); #2;
        chk("R10 idle cycle", {31'b0, out_valid}, 0);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h0;
        regs[0] = 32'h00111111;
        regs[3] = 32'h00001000;
        regs[5] = 32'h00FFFFF0;
        regs[8] = 32'h12ABCDEF;
        repeat (3) @(posedge clk);
        #2;
        t_reset;
        rst_n = 1'b1;
        @(posedge clk); #2;
        t_cc_add;
        t_mask_table;
        t_reg_form;
        t_idx_form;
        t_same_cycle;
        t_other_op;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule